// File: doc/BRIEF.md
# MSI-X Capability Register Block

This block holds the MSI-X capability structure that sits inside a PCI function's configuration space. It answers configuration reads and writes addressed to the capability's own bytes, from byte 0 to byte 11. The first byte is the capability identifier and the second is the pointer to the next capability. These are followed by a 16-bit message control word, then a dword that locates the vector table and a dword that locates the pending-bit array. The message control word exposes the vector count. Its two top bits, the global enable and the function-wide mask, are the only state software can change.

The enable bit, the mask bit and the table size are driven out to the engine that owns the vector table. A write can make interrupt delivery possible where it was not possible before. In that case the block raises a single-cycle rescan pulse, so that the table engine sends any vectors that were held pending. The vector count, the BAR index that holds the table and the next-capability pointer are parameters.

Top module: `msix_cap_regs`

## Requirements
- R1: Capability byte 0 reads 0x11 and byte 1 reads the NEXT_PTR parameter. Writes to either byte have no effect.
- R2: Message control bits 10:0 read VEC_COUNT-1, and the `tbl_size` output equals VEC_COUNT.
- R3: Message control bits 13:0 are read-only, and bits 13:11 read 0.
- R4: Message control bit 15 is the enable and bit 14 is the function mask. A write changes them only through a lane that lands on capability byte 3, and the new values show on `msix_en` and `msix_fmask` in the cycle after the write. A write that covers only byte 2 leaves them unchanged.
- R5: The dword at byte 4 reads BAR_IDX, which means table offset 0. The dword at byte 8 reads 0x800 OR BAR_IDX.
- R6: Writes to bytes 4 to 11, and to offsets 12 to 15, change no register. Reads of offsets 12 to 15 return 0.
- R7: `cfg_size` 0 reads 1 byte, 1 reads 2 bytes, and 2 or 3 read 4 bytes. Lane k of `cfg_rdata` carries capability byte `cfg_addr`+k. Lanes past the access size, or past byte 11, read 0. `cfg_rdata` is loaded on the clock edge that samples `cfg_rd` and holds at all other times.
- R8: In the cycle after a write, `rescan` pulses high for one cycle when the write moves the function from not deliverable to deliverable. Deliverable means enable is 1 and mask is 0. This covers setting enable while the mask is clear, and clearing the mask while enable is set.
- R9: No rescan follows in these cases: enable is set while the mask is set, the mask is cleared while enable is clear, a write leaves the state unchanged, or a write disables delivery.
- R10: After reset, enable, mask, rescan and `cfg_rdata` are all 0.
- R11: All lanes of one access are applied together, including unaligned and multi-byte writes, and one access yields at most one rescan pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Byte offset within the capability |
| cfg_size | input | 2 | Access size code: 0 one byte, 1 two bytes, 2 or 3 four bytes |
| cfg_wdata | input | 32 | Write data, lane k aimed at byte cfg_addr+k |
| cfg_rdata | output | 32 | Registered read data |
| msix_en | output | 1 | MSI-X global enable |
| msix_fmask | output | 1 | Function-wide mask |
| tbl_size | output | 12 | Number of table entries |
| rescan | output | 1 | One-cycle pulse: re-examine pending vectors |

## Verification
The bound checker covers the timing of enable, mask and rescan on every cycle. Rescan lasts exactly one cycle, follows a write, and appears only when delivery has just become possible. Enable, mask and read data hold steady when no access occurs. Only the directed scenarios can show the byte image itself. That includes the lane steering for unaligned and short accesses, the read-only fields surviving all-ones writes, and rescan staying silent for each near-miss combination of enable and mask.

// File: rtl/msix_cap_pkg.sv
// Package: shared constants and helpers for the MSI-X capability block.
// Assumes the capability occupies 12 bytes and is reached via 32-bit lanes.
package msix_cap_pkg;

    localparam int          CAP_BYTES   = 12;
    localparam int          LANES       = 4;
    localparam int          ADDR_W      = 4;
    localparam logic [7:0]  CAP_ID_MSIX = 8'h11;
    localparam logic [31:0] PBA_OFFSET  = 32'h0000_0800;
    localparam int          CTRL_HI_BYTE = 3;   // byte holding enable/mask
    localparam int          HI_EN_BIT    = 7;   // bit 15 of message control
    localparam int          HI_MASK_BIT  = 6;   // bit 14 of message control
    localparam int          TS_W         = 11;  // table size field width

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_WIDE  = 2'd3
    } acc_size_e;

    typedef logic [CAP_BYTES-1:0][7:0] cap_image_t;

    // Number of byte lanes taking part in an access of the given size.
    function automatic int lane_count(input logic [1:0] sz);
        case (acc_size_e'(sz))
            SZ_BYTE: return 1;
            SZ_WORD: return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/msix_lane_steer.sv
// Lane steering: maps the byte lanes of one access onto capability bytes.
// Emits the write strobe/data for the one writable byte (WR_BYTE) and
// assembles right-aligned read data from the capability image.
// Assumes lanes past the access size or past the image read as zero.
module msix_lane_steer
    import msix_cap_pkg::*;
#(
    parameter int WR_BYTE = CTRL_HI_BYTE
) (
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [1:0]         acc_size,
    input  logic               acc_wr,
    input  logic [LANES*8-1:0] acc_wdata,
    input  cap_image_t         image,
    output logic               byte_we,
    output logic [7:0]         byte_wd,
    output logic [LANES*8-1:0] rd_word
);

    localparam int LAST_LANE = LANES - 1;

    int n_lanes;
    assign n_lanes = lane_count(acc_size);

    // Find the lane, if any, that lands on the writable byte.
    always_comb begin
        byte_we = 1'b0;
        byte_wd = 8'h00;
        for (int l = 0; l <= LAST_LANE; l++) begin
            if (l < n_lanes && (int'(acc_addr) + l) == WR_BYTE) begin
                byte_we = acc_wr;
                byte_wd = acc_wdata[8*l +: 8];
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_rd_lane
        logic [7:0] lane_val;
        // Select the image byte seen by this read lane.
        always_comb begin
            lane_val = 8'h00;
            for (int b = 0; b < CAP_BYTES; b++) begin
                if (l < n_lanes && (int'(acc_addr) + l) == b)
                    lane_val = image[b];
            end
        end
        assign rd_word[8*l +: 8] = lane_val;
    end

endmodule

// File: rtl/msix_ctrl_bits.sv
// Control bits: holds the enable and function-mask bits of message control
// and raises a one-cycle rescan when delivery becomes possible.
// Assumes one write strobe per access carrying the high control byte.
module msix_ctrl_bits
    import msix_cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hi_we,
    input  logic [7:0] hi_wd,
    output logic       en_q,
    output logic       mask_q,
    output logic       rescan_q
);

    logic en_d, mask_d, live_now, live_next;

    // Next-state of the two writable bits.
    always_comb begin
        en_d   = en_q;
        mask_d = mask_q;
        if (hi_we) begin
            en_d   = hi_wd[HI_EN_BIT];
            mask_d = hi_wd[HI_MASK_BIT];
        end
        live_now  = en_q & ~mask_q;
        live_next = en_d & ~mask_d;
    end

    // Register the bits and the delivery-just-opened pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            mask_q   <= 1'b0;
            rescan_q <= 1'b0;
        end else begin
            en_q     <= en_d;
            mask_q   <= mask_d;
            rescan_q <= hi_we & ~live_now & live_next;
        end
    end

endmodule

// File: rtl/msix_cap_image.sv
// Capability image: builds the 12-byte view of the structure from the
// parameters and the live control bits. Purely combinational.
// Assumes BAR_IDX fits in the 3-bit indicator field (0..5).
module msix_cap_image
    import msix_cap_pkg::*;
#(
    parameter int         VEC_COUNT = 64,
    parameter int         BAR_IDX   = 2,
    parameter logic [7:0] NEXT_PTR  = 8'h70
) (
    input  logic       en,
    input  logic       mask,
    output cap_image_t image
);

    localparam logic [TS_W-1:0] TS_FIELD = TS_W'(VEC_COUNT - 1);
    localparam logic [31:0]     TBL_DW   = 32'(BAR_IDX);
    localparam logic [31:0]     PBA_DW   = PBA_OFFSET | 32'(BAR_IDX);

    logic [15:0] msg_ctrl;

    // Assemble message control: writable top bits, zero reserved, size.
    assign msg_ctrl = {en, mask, 3'b000, TS_FIELD};

    // Lay out the bytes of the structure.
    always_comb begin
        image[0] = CAP_ID_MSIX;
        image[1] = NEXT_PTR;
        image[2] = msg_ctrl[7:0];
        image[3] = msg_ctrl[15:8];
        for (int k = 0; k < 4; k++) begin
            image[4 + k] = TBL_DW[8*k +: 8];
            image[8 + k] = PBA_DW[8*k +: 8];
        end
    end

endmodule

// File: rtl/msix_cap_regs.sv
// MSI-X capability register block (top). Serves byte-lane configuration
// accesses at the capability's base, exports enable/mask/size to the table
// engine and pulses rescan when delivery opens up.
// Assumes cfg_addr is relative to the capability start.
module msix_cap_regs
    import msix_cap_pkg::*;
#(
    parameter int         VEC_COUNT = 64,
    parameter int         BAR_IDX   = 2,
    parameter logic [7:0] NEXT_PTR  = 8'h70
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_rd,
    input  logic        cfg_wr,
    input  logic [3:0]  cfg_addr,
    input  logic [1:0]  cfg_size,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        msix_en,
    output logic        msix_fmask,
    output logic [11:0] tbl_size,
    output logic        rescan
);

    localparam logic [11:0] TBL_SIZE = 12'(VEC_COUNT);

    cap_image_t  image;
    logic        hi_we;
    logic [7:0]  hi_wd;
    logic [31:0] rd_word;

    msix_lane_steer #(.WR_BYTE(CTRL_HI_BYTE)) i_steer (
        .acc_addr (cfg_addr),
        .acc_size (cfg_size),
        .acc_wr   (cfg_wr),
        .acc_wdata(cfg_wdata),
        .image    (image),
        .byte_we  (hi_we),
        .byte_wd  (hi_wd),
        .rd_word  (rd_word)
    );

    msix_ctrl_bits i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_we   (hi_we),
        .hi_wd   (hi_wd),
        .en_q    (msix_en),
        .mask_q  (msix_fmask),
        .rescan_q(rescan)
    );

    msix_cap_image #(
        .VEC_COUNT(VEC_COUNT),
        .BAR_IDX  (BAR_IDX),
        .NEXT_PTR (NEXT_PTR)
    ) i_image (
        .en   (msix_en),
        .mask (msix_fmask),
        .image(image)
    );

    assign tbl_size = TBL_SIZE;

    // Capture read data on a read strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_rdata <= '0;
        else if (cfg_rd)
            cfg_rdata <= rd_word;
    end

endmodule

// File: rtl/msix_cap_chk.sv
// Checker: cycle-level properties of the control bits, rescan and read data.
// Bound into every msix_cap_regs instance.
module msix_cap_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_rd,
    input logic        cfg_wr,
    input logic [31:0] cfg_rdata,
    input logic        msix_en,
    input logic        msix_fmask,
    input logic        rescan
);

    assert_rescan_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rescan |=> !rescan);

    assert_rescan_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rescan |-> $past(cfg_wr));

    assert_rescan_deliverable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rescan |-> (msix_en && !msix_fmask));

    assert_rescan_was_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rescan |-> !($past(msix_en) && !$past(msix_fmask)));

    assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ($stable(msix_en) && $stable(msix_fmask)));

    assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd |=> $stable(cfg_rdata));

endmodule

bind msix_cap_regs msix_cap_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rd    (cfg_rd),
    .cfg_wr    (cfg_wr),
    .cfg_rdata (cfg_rdata),
    .msix_en   (msix_en),
    .msix_fmask(msix_fmask),
    .rescan    (rescan)
);

// File: tb/test_msix_cap_regs.sv
module test_msix_cap_regs;

    localparam int         VEC = 64;
    localparam int         BAR = 2;
    localparam logic [7:0] NXT = 8'h70;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_rd = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [1:0]  cfg_size = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        msix_en, msix_fmask, rescan;
    logic [11:0] tbl_size;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    msix_cap_regs #(.VEC_COUNT(VEC), .BAR_IDX(BAR), .NEXT_PTR(NXT)) i_msix_cap_regs (
        .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .msix_en(msix_en), .msix_fmask(msix_fmask),
        .tbl_size(tbl_size), .rescan(rescan)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One write access; returns at the negedge after the capturing edge.
    task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_size = s; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_addr = a; cfg_size = s;
        @(negedge clk);
        cfg_rd = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic t_reset();
        chk("R10 en", 32'(msix_en), 0);
        chk("R10 mask", 32'(msix_fmask), 0);
        chk("R10 rescan", 32'(rescan), 0);
        chk("R10 rdata", cfg_rdata, 0);
        chk("R2 tbl_size", 32'(tbl_size), VEC);
    endtask

    task automatic t_read_image();
        logic [31:0] d;
        rd(4'd0, 2'd2, d); chk("R1 R2 R3 dword0", d, 32'h003F_7011);
        rd(4'd1, 2'd0, d); chk("R1 next ptr byte", d, 32'h70);
        rd(4'd2, 2'd1, d); chk("R2 msg ctrl word", d, 32'h003F);
        rd(4'd4, 2'd2, d); chk("R5 table dword", d, 32'h2);
        rd(4'd8, 2'd2, d); chk("R5 pba dword", d, 32'h802);
        rd(4'd9, 2'd2, d); chk("R7 past end", d, 32'h08);
        rd(4'd1, 2'd1, d); chk("R7 unaligned word", d, 32'h3F70);
        rd(4'd0, 2'd3, d); chk("R7 size code 3", d, 32'h003F_7011);
        rd(4'd14, 2'd0, d); chk("R6 beyond image", d, 0);
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        wr(4'd0, 2'd2, 32'hFFFF_FFFF);
        chk("R9 en set under mask no rescan", 32'(rescan), 0);
        chk("R4 en", 32'(msix_en), 1);
        chk("R4 mask", 32'(msix_fmask), 1);
        rd(4'd0, 2'd2, d); chk("R1 R3 after ones write", d, 32'hC03F_7011);
        wr(4'd4, 2'd2, 32'hFFFF_FFFF);
        wr(4'd8, 2'd2, 32'hFFFF_FFFF);
        wr(4'd12, 2'd2, 32'hFFFF_FFFF);
        rd(4'd4, 2'd2, d); chk("R6 table after write", d, 32'h2);
        rd(4'd8, 2'd2, d); chk("R6 pba after write", d, 32'h802);
        chk("R6 ctrl untouched", {msix_en, msix_fmask}, 2'b11);
    endtask

    task automatic t_unmask_rescan();
        wr(4'd3, 2'd0, 32'h80);
        chk("R8 rescan on unmask", 32'(rescan), 1);
        @(negedge clk);
        chk("R8 rescan one cycle", 32'(rescan), 0);
        wr(4'd2, 2'd1, 32'h0000);
        chk("R4 en cleared", 32'(msix_en), 0);
        chk("R9 disable no rescan", 32'(rescan), 0);
        wr(4'd2, 2'd0, 32'hFF);
        chk("R4 low byte only no effect", {msix_en, msix_fmask}, 2'b00);
    endtask

    task automatic t_near_misses();
        wr(4'd3, 2'd0, 32'h40);
        chk("R9 mask only", 32'(rescan), 0);
        wr(4'd3, 2'd0, 32'h00);
        chk("R9 unmask while disabled", 32'(rescan), 0);
        chk("R4 mask cleared", 32'(msix_fmask), 0);
        wr(4'd2, 2'd1, 32'h8000);
        chk("R11 word write enables", 32'(rescan), 1);
        wr(4'd2, 2'd1, 32'h8000);
        chk("R9 repeat no rescan", 32'(rescan), 0);
        wr(4'd3, 2'd0, 32'h00);
        wr(4'd1, 2'd2, 32'h0080_0000);
        chk("R11 unaligned dword lane", 32'(rescan), 1);
        chk("R4 en via lane 2", 32'(msix_en), 1);
        @(negedge clk);
        chk("R11 single pulse", 32'(rescan), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_image();
        t_readonly();
        t_unmask_rescan();
        t_near_misses();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule